// File: doc/BRIEF.md
# Receive Data Queue with Masked Interrupt

This block is one slice of a memory-card host peripheral on an APB bus. A card-side write port pushes 32-bit words into a sixteen-entry queue. Software drains the queue by reading a fixed data window over APB. Each read of that window removes one word.

A read-only status word reports five conditions. Four of them are level flags that follow the queue fill level: full, empty, half-full and data-available. The fifth is a sticky overrun error, which is set when the card side pushes into a full queue. Software drops the overrun flag by writing a one to the matching bit of a write-only clear word.

A read/write mask word selects which status bits raise the single interrupt request. The half-full level is also driven out as a DMA request, so a DMA engine can drain the queue in bursts of eight words.

The APB interface has two parts. A small state machine follows the bus phases: `PH_IDLE` goes to `PH_SETUP` when PSEL rises without PENABLE. `PH_SETUP` goes to `PH_ACCESS` when PENABLE is asserted. `PH_ACCESS` returns to `PH_SETUP` for a back-to-back transfer, or to `PH_IDLE` otherwise. A register access takes effect only in the cycle where the machine is in `PH_SETUP` with PENABLE high.

Register offsets are 0x34 for status, 0x38 for clear, 0x3C for mask and 0x80 for the data window. The status bits are: bit 0 full, bit 1 empty, bit 2 half-full, bit 3 data-available and bit 4 overrun. Bits 21:5 of the status word read as zero.

Top module: `rxq_apb_top`

## Requirements
- R1: The queue holds 16 words. Status bit 0 (full) is 1 exactly when 16 words are held.
- R2: Status bit 1 (empty) is 1 exactly when no word is held. Status bit 3 (data-available) is always the inverse of bit 1.
- R3: Status bit 2 (half-full) is 1 when 8 or more words are held. `dma_req` equals that bit as it was one cycle earlier.
- R4: Words come out of the window at offset 0x80 in the order they were pushed. Each read of the window with data present removes exactly one word.
- R5: A push while the queue is full sets status bit 4 (overrun). The pushed word is discarded and the held words are unchanged. Bit 4 stays 1 until it is cleared.
- R6: A write to offset 0x38 clears status bit 4 only if data bit 4 is 1. If a push into the full queue happens in the same cycle, bit 4 stays set. Clear writes never change bits 0 to 3.
- R7: The mask word at 0x3C is read/write, 22 bits wide and resets to 0. `irq_req` equals the OR of (status AND mask) as it was one cycle earlier.
- R8: A read of the window while the queue is empty returns 0 and leaves the queue unchanged.
- R9: PREADY is always 1. PSLVERR is 1 during the access phase of a transfer to any offset other than 0x34, 0x38, 0x3C and 0x80, and 0 otherwise.
- R10: After reset the status word reads 0x00000002, the mask reads 0, and `irq_req` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for undefined offsets |
| rx_wr_valid | input | 1 | Card-side push strobe |
| rx_wr_data | input | 32 | Card-side push word |
| irq_req | output | 1 | Registered masked interrupt request |
| dma_req | output | 1 | Registered half-full DMA request |

## Verification
A wrong fill count or pointer shows up at the very next status or window read. The flag pattern stops matching the number of words pushed minus the number popped, or the drained sequence skips, repeats or leaks a discarded word.

A fault in the sticky overrun logic or the clear logic is visible on the first status read after the push into the full queue or after the clear write. A fault in the mask path shows on `irq_req` one cycle after the condition changes, and a fault in the half-full path shows on `dma_req` with the same one-cycle delay.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} apb_phase_e;

    localparam int STAT_W = 22;
    localparam int CLR_W  = 11;

    localparam int B_FULL  = 0;
    localparam int B_EMPTY = 1;
    localparam int B_HALF  = 2;
    localparam int B_AVAIL = 3;
    localparam int B_OVR   = 4;

    localparam logic [7:0] OFS_STAT = 8'h34;
    localparam logic [7:0] OFS_CLR  = 8'h38;
    localparam logic [7:0] OFS_MASK = 8'h3C;
    localparam logic [7:0] OFS_WIN  = 8'h80;
endpackage

// File: rtl/rxq_apb_phase.sv
module rxq_apb_phase
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic acc_rd,
    output logic acc_wr,
    output logic in_access
);
    apb_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (psel && !penable) state_d = PH_SETUP;
            PH_SETUP:  if (penable) state_d = PH_ACCESS;
                       else if (!psel) state_d = PH_IDLE;
            PH_ACCESS: state_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_access = (state_q == PH_SETUP) && psel && penable;
        acc_rd    = in_access && !pwrite;
        acc_wr    = in_access && pwrite;
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST     = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic          do_push, do_pop;

    assign do_push = push_req && (count != FULL_CNT);
    assign do_pop  = pop_req && (count != '0);
    assign head    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count,
    input  logic              push_req,
    input  logic              clr_wr,
    input  logic [CLR_W-1:0]  clr_data,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_data,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask_q,
    output logic              ovr_q,
    output logic              irq_q,
    output logic              dma_q
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic is_full, is_empty, is_half, ovr_set, ovr_clr;

    always_comb begin
        is_full  = (count == FULL_CNT);
        is_empty = (count == '0);
        is_half  = (count >= HALF_CNT);
        ovr_set  = push_req && is_full;
        ovr_clr  = clr_wr && clr_data[B_OVR];
        status          = '0;
        status[B_FULL]  = is_full;
        status[B_EMPTY] = is_empty;
        status[B_HALF]  = is_half;
        status[B_AVAIL] = !is_empty;
        status[B_OVR]   = ovr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            mask_q <= '0;
            irq_q  <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (ovr_set)      ovr_q <= 1'b1;
            else if (ovr_clr) ovr_q <= 1'b0;
            if (mask_wr) mask_q <= mask_data;
            irq_q <= |(status & mask_q);
            dma_q <= is_half;
        end
    end
endmodule

// File: rtl/rxq_apb_top.sv
module rxq_apb_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic          rx_wr_valid,
    input  logic [DW-1:0] rx_wr_data,
    output logic          irq_req,
    output logic          dma_req
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              acc_rd, acc_wr, in_access;
    logic              hit_stat, hit_clr, hit_mask, hit_win, known;
    logic              pop_req, clr_wr, mask_wr;
    logic [DW-1:0]     head;
    logic [CW-1:0]     count;
    logic [STAT_W-1:0] status, mask_q;
    logic              ovr_q;
    logic              unused_bits;

    assign unused_bits = ^{pwdata[DW-1:STAT_W], paddr[1:0]};

    rxq_apb_phase u_phase (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .acc_rd(acc_rd), .acc_wr(acc_wr), .in_access(in_access)
    );

    always_comb begin
        hit_stat = (paddr[AW-1:2] == OFS_STAT[AW-1:2]);
        hit_clr  = (paddr[AW-1:2] == OFS_CLR[AW-1:2]);
        hit_mask = (paddr[AW-1:2] == OFS_MASK[AW-1:2]);
        hit_win  = (paddr[AW-1:2] == OFS_WIN[AW-1:2]);
        known    = hit_stat || hit_clr || hit_mask || hit_win;
        pop_req  = acc_rd && hit_win;
        clr_wr   = acc_wr && hit_clr;
        mask_wr  = acc_wr && hit_mask;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(pclk), .rst_n(presetn), .push_req(rx_wr_valid),
        .push_data(rx_wr_data), .pop_req(pop_req), .head(head), .count(count)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(pclk), .rst_n(presetn), .count(count), .push_req(rx_wr_valid),
        .clr_wr(clr_wr), .clr_data(pwdata[CLR_W-1:0]),
        .mask_wr(mask_wr), .mask_data(pwdata[STAT_W-1:0]),
        .status(status), .mask_q(mask_q), .ovr_q(ovr_q),
        .irq_q(irq_req), .dma_q(dma_req)
    );

    always_comb begin
        prdata = '0;
        if (acc_rd) begin
            if (hit_stat)      prdata = DW'(status);
            else if (hit_mask) prdata = DW'(mask_q);
            else if (hit_win)  prdata = (count == '0) ? '0 : head;
        end
    end

    assign pready  = 1'b1;
    assign pslverr = in_access && !known;
endmodule

// File: rtl/rxq_apb_chk.sv
module rxq_apb_chk
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              pop_req,
    input logic              clr_wr,
    input logic              clr_bit,
    input logic [CW-1:0]     count,
    input logic              ovr_q,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] mask_q,
    input logic              irq,
    input logic              dma,
    input logic              pready
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) && push_req && !pop_req |=> count == CW'(DEPTH)); // R5
    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) && push_req |=> ovr_q); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && !(clr_wr && clr_bit) |=> ovr_q); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(status & mask_q))); // R7
    AST_DMA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        dma == $past(count >= CW'(DEPTH / 2))); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) && pop_req && !push_req |=> count == '0); // R8
    AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        pready); // R9
endmodule

bind rxq_apb_top rxq_apb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(pclk), .rst_n(presetn), .push_req(rx_wr_valid), .pop_req(pop_req),
    .clr_wr(clr_wr), .clr_bit(pwdata[rxq_pkg::B_OVR]), .count(count),
    .ovr_q(ovr_q), .status(status), .mask_q(mask_q), .irq(irq_req),
    .dma(dma_req), .pready(pready)
);

// File: tb/rxq_apb_top_bench.sv
module rxq_apb_top_bench;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        rx_wr_valid = 1'b0;
    logic [31:0] rx_wr_data = '0;
    logic        irq_req, dma_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 pclk = ~pclk;

    rxq_apb_top u_rxq_apb_top (.*);

    // entry: {fill level after pushes, expected status[4:0]}
    localparam logic [12:0] VEC [0:5] = '{
        {8'd1,  5'h08}, {8'd7,  5'h08}, {8'd8,  5'h0C},
        {8'd12, 5'h0C}, {8'd15, 5'h0C}, {8'd16, 5'h0D}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge pclk); rx_wr_valid = 1'b1; rx_wr_data = d;
        @(negedge pclk); rx_wr_valid = 1'b0;
    endtask

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        @(negedge pclk); psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1'b1;
        #1; rd = prdata; err = pslverr;
        @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        logic        err;
        int          level;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        // reset state
        apb(0, 8'h34, 0, rd, err); check("R10 status", rd, 32'h2);
        check("R2 empty at reset", {31'b0, rd[1]}, 1);
        apb(0, 8'h3C, 0, rd, err); check("R10 mask", rd, 0);
        check("R10 irq", {31'b0, irq_req}, 0);
        check("R10 dma", {31'b0, dma_req}, 0);
        check("R9 pready", {31'b0, pready}, 1);

        // fill walk: R1 R2 R3
        level = 0;
        for (int i = 0; i < 6; i++) begin
            while (level < int'(VEC[i][12:5])) begin
                push(32'hA500_0000 + level);
                level++;
            end
            apb(0, 8'h34, 0, rd, err);
            check("R1/R2/R3 flags", rd, {27'b0, VEC[i][4:0]});
            check("R3 dma_req", {31'b0, dma_req}, {31'b0, VEC[i][2]});
        end

        // overrun: R5
        push(32'hDEAD_BEEF);
        apb(0, 8'h34, 0, rd, err); check("R5 overrun set", rd, 32'h1D);
        // clear without bit 4: R6
        apb(1, 8'h38, 32'h7EF, rd, err);
        apb(0, 8'h34, 0, rd, err); check("R6 clear bit4=0 keeps", rd, 32'h1D);
        apb(1, 8'h38, 32'h010, rd, err);
        apb(0, 8'h34, 0, rd, err); check("R6 clear drops overrun only", rd, 32'h0D);

        // drain in order: R4 R5
        for (int i = 0; i < 16; i++) begin
            apb(0, 8'h80, 0, rd, err);
            check("R4 order", rd, 32'hA500_0000 + i);
        end
        apb(0, 8'h34, 0, rd, err); check("R5 discarded word absent", rd, 32'h2);
        check("R3 dma low", {31'b0, dma_req}, 0);

        // empty read: R8
        apb(0, 8'h80, 0, rd, err); check("R8 empty read zero", rd, 0);
        apb(0, 8'h34, 0, rd, err); check("R8 still empty", rd, 32'h2);
        push(32'h1234_5678);
        apb(0, 8'h80, 0, rd, err); check("R8 pointer unchanged", rd, 32'h1234_5678);

        // mask and irq: R7
        apb(1, 8'h3C, 32'hFFFF_FFFF, rd, err);
        apb(0, 8'h3C, 0, rd, err); check("R7 mask width", rd, 32'h003F_FFFF);
        apb(1, 8'h3C, 32'h2, rd, err);
        @(negedge pclk);
        check("R7 irq on empty", {31'b0, irq_req}, 1);
        apb(1, 8'h3C, 32'h1, rd, err);
        @(negedge pclk);
        check("R7 irq masked off", {31'b0, irq_req}, 0);
        apb(1, 8'h3C, 32'h10, rd, err);
        for (int i = 0; i < 17; i++) push(i);
        @(negedge pclk);
        check("R7 irq on overrun", {31'b0, irq_req}, 1);
        apb(1, 8'h38, 32'h10, rd, err);
        @(negedge pclk);
        check("R7 irq after clear", {31'b0, irq_req}, 0);

        // bus errors: R9
        apb(0, 8'h40, 0, rd, err); check("R9 undefined offset err", {31'b0, err}, 1);
        apb(1, 8'h00, 0, rd, err); check("R9 undefined write err", {31'b0, err}, 1);
        apb(0, 8'h34, 0, rd, err); check("R9 known offset no err", {31'b0, err}, 0);
        check("R9 pready", {31'b0, pready}, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge pclk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule